// File: doc/BRIEF.md
# Write-only I2C command target

This block is a receive-only I2C target. It listens on an oversampled SCL/SDA pair taken from a fast system clock and answers one fixed 7-bit address. A transfer carries one address byte and then three data bytes. Each data byte is acknowledged and placed in a holding byte of its own. The 24-bit command word seen by the rest of the chip changes only when a STOP follows a complete three-byte set.

A transfer that breaks off early leaves the command word as it was. A complete set that is still waiting for its STOP survives repeated STARTs that address other targets. Both SCL and SDA pass through a two-flop synchroniser and a stability filter, so pulses shorter than the filter window have no effect. One bit of the committed word drives a separate force-on output for an external converter.

Top module: `i2c_cmd_target`

## Requirements
- R1: An address byte of 0x36 (7-bit address 0x1B, then R/W = 0), sent MSB first after a START, is acknowledged.
- R2: An address byte with R/W = 1 (0x37) or any other address gets no acknowledge. No byte that follows it is acknowledged until the next START.
- R3: The acknowledge pull-down `sda_oe_o` rises only while the filtered SCL is low, after the eighth bit of a byte. It holds SDA low through the whole high phase of the ninth clock.
- R4: After an acknowledged address, exactly three data bytes are acknowledged. A fourth byte gets no acknowledge.
- R5: `cmd_o` changes only on a STOP that follows a complete set of three data bytes. The first byte lands in `cmd_o[23:16]`, the second in `[15:8]` and the third in `[7:0]`.
- R6: A STOP that arrives before the third data byte leaves `cmd_o` unchanged. Bytes clocked after it without a new START are not acknowledged.
- R7: A complete set that has not been committed is committed by any later STOP, even after repeated STARTs to other addresses.
- R8: When a repeated START addresses this target and is acknowledged, the waiting set is discarded. A STOP after only one new data byte then leaves `cmd_o` unchanged.
- R9: A level change on SCL or SDA that lasts fewer than `FILT_CYC` system clocks is ignored.
- R10: Reset clears `cmd_o` to zero and releases `sda_oe_o`. `force_o` always equals `cmd_o[19]`, which is bit 3 of the first data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Raw SCL level from the pad |
| sda_i | input | 1 | Raw SDA level from the pad |
| sda_oe_o | output | 1 | Enables the SDA pull-down for an acknowledge |
| cmd_o | output | 24 | Committed command word |
| force_o | output | 1 | Force-on request taken from the committed word |

## Verification
Some properties are checked by assertions on every cycle. The command word changes only in the cycle after a detected STOP, and never after a STOP when no set is waiting. The acknowledge pull-down rises only while the filtered SCL is low. A filtered line changes only to a level the synchroniser has already shown. Other behaviours need whole bus sequences from the bench: acknowledge decisions, the byte-to-field mapping, discarded partial transfers, sets carried across repeated STARTs, a set discarded when this target is re-addressed, and a rejected SCL spike. The bench compares each of these against its behavioural model.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_DATA,
    ST_DATA_ACK,
    ST_SKIP
  } tgt_state_e;
endpackage

// File: rtl/i2c_in_filter.sv
module i2c_in_filter #(
  parameter int FILT_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic line_o
);
  localparam int CW = $clog2(FILT_CYC + 1);

  logic [1:0]    sync_q;
  logic          line_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b11;
      line_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], raw_i};
      if (sync_q[1] == line_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(FILT_CYC - 1)) begin
        line_q <= sync_q[1];
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign line_o = line_q;

  // R9: filtered level only moves to a level already seen at the synchroniser
  a_r9_filter_follows_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(line_q) |-> $past(sync_q[1]) == line_q);
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign start_o    = scl_q & scl_i & sda_q & ~sda_i;
  assign stop_o     = scl_q & scl_i & ~sda_q & sda_i;
  assign scl_rise_o = ~scl_q & scl_i;
  assign scl_fall_o = scl_q & ~scl_i;
endmodule

// File: rtl/i2c_wr_fsm.sv
module i2c_wr_fsm
  import i2c_cmd_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR  = 7'h1B,
  parameter int         NUM_BYTES = 3
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         scl_i,
  input  logic                         sda_i,
  input  logic                         start_i,
  input  logic                         stop_i,
  input  logic                         scl_rise_i,
  input  logic                         scl_fall_i,
  output logic                         sda_oe_o,
  output logic                         addr_hit_o,
  output logic                         wr_en_o,
  output logic [$clog2(NUM_BYTES)-1:0] wr_idx_o,
  output logic [7:0]                   wr_data_o
);
  localparam int IW = $clog2(NUM_BYTES);

  tgt_state_e state_q;
  logic [7:0]    sr_q;
  logic [3:0]    bit_q;
  logic [IW-1:0] idx_q;
  logic          oe_q, hit_q, wr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sr_q    <= '0;
      bit_q   <= '0;
      idx_q   <= '0;
      oe_q    <= 1'b0;
      hit_q   <= 1'b0;
      wr_q    <= 1'b0;
    end else begin
      hit_q <= 1'b0;
      wr_q  <= 1'b0;
      if (start_i) begin
        state_q <= ST_ADDR;
        bit_q   <= '0;
        oe_q    <= 1'b0;
      end else if (stop_i) begin
        state_q <= ST_IDLE;
        oe_q    <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR, ST_DATA: begin
            if (scl_rise_i && bit_q != 4'd8) begin
              sr_q  <= {sr_q[6:0], sda_i};
              bit_q <= bit_q + 1'b1;
            end else if (scl_fall_i && bit_q == 4'd8) begin
              bit_q <= '0;
              if (state_q == ST_DATA) begin
                oe_q    <= 1'b1;
                wr_q    <= 1'b1;
                state_q <= ST_DATA_ACK;
              end else if (sr_q == {DEV_ADDR, 1'b0}) begin
                oe_q    <= 1'b1;
                hit_q   <= 1'b1;
                state_q <= ST_ADDR_ACK;
              end else begin
                state_q <= ST_SKIP;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall_i) begin
              oe_q    <= 1'b0;
              idx_q   <= '0;
              state_q <= ST_DATA;
            end
          end
          ST_DATA_ACK: begin
            if (scl_fall_i) begin
              oe_q <= 1'b0;
              if (idx_q == IW'(NUM_BYTES - 1)) begin
                state_q <= ST_SKIP;
              end else begin
                idx_q   <= idx_q + 1'b1;
                state_q <= ST_DATA;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o   = oe_q;
  assign addr_hit_o = hit_q;
  assign wr_en_o    = wr_q;
  assign wr_idx_o   = idx_q;
  assign wr_data_o  = sr_q;

  // R3: acknowledge pull-down is only switched on with SCL low
  a_r3_ack_rises_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_q) |-> !scl_i);
  // R3: pull-down is held while SCL is high
  a_r3_ack_held_scl_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(oe_q) && scl_i && !stop_i && !start_i) |-> oe_q);
endmodule

// File: rtl/i2c_cmd_store.sv
module i2c_cmd_store #(
  parameter int NUM_BYTES = 3
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         stop_i,
  input  logic                         addr_hit_i,
  input  logic                         wr_en_i,
  input  logic [$clog2(NUM_BYTES)-1:0] wr_idx_i,
  input  logic [7:0]                   wr_data_i,
  output logic [8*NUM_BYTES-1:0]       cmd_o
);
  localparam int IW = $clog2(NUM_BYTES);
  localparam int CW = 8 * NUM_BYTES;

  logic [7:0]    hold_q [NUM_BYTES];
  logic [CW-1:0] hold_flat;
  logic [CW-1:0] cmd_q;
  logic          pending_q;

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_hold
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            hold_q[g] <= '0;
      else if (wr_en_i && wr_idx_i == IW'(g)) hold_q[g] <= wr_data_i;
    end
    assign hold_flat[CW-1-8*g -: 8] = hold_q[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_q <= 1'b0;
      cmd_q     <= '0;
    end else begin
      if (stop_i && pending_q) begin
        cmd_q     <= hold_flat;
        pending_q <= 1'b0;
      end else if (addr_hit_i) begin
        pending_q <= 1'b0;
      end else if (wr_en_i && wr_idx_i == IW'(NUM_BYTES - 1)) begin
        pending_q <= 1'b1;
      end
    end
  end

  assign cmd_o = cmd_q;

  // R5: command word moves only right after a STOP
  a_r5_cmd_only_on_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cmd_q) |-> $past(stop_i));
  // R6: STOP without a complete set leaves the word alone
  a_r6_no_commit_without_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !pending_q) |=> $stable(cmd_q));
endmodule

// File: rtl/i2c_cmd_target.sv
module i2c_cmd_target #(
  parameter int         FILT_CYC  = 8,
  parameter logic [6:0] DEV_ADDR  = 7'h1B,
  parameter int         NUM_BYTES = 3,
  parameter int         FORCE_BIT = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   scl_i,
  input  logic                   sda_i,
  output logic                   sda_oe_o,
  output logic [8*NUM_BYTES-1:0] cmd_o,
  output logic                   force_o
);
  localparam int IW = $clog2(NUM_BYTES);
  localparam int CW = 8 * NUM_BYTES;

  logic [1:0] raw, filt;
  logic start, stop, scl_rise, scl_fall;
  logic addr_hit, wr_en;
  logic [IW-1:0] wr_idx;
  logic [7:0] wr_data;

  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_filt
    i2c_in_filter #(.FILT_CYC(FILT_CYC)) i_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .raw_i (raw[g]),
      .line_o(filt[g])
    );
  end

  i2c_bus_events i_events (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (filt[1]),
    .sda_i     (filt[0]),
    .start_o   (start),
    .stop_o    (stop),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall)
  );

  i2c_wr_fsm #(.DEV_ADDR(DEV_ADDR), .NUM_BYTES(NUM_BYTES)) i_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (filt[1]),
    .sda_i     (filt[0]),
    .start_i   (start),
    .stop_i    (stop),
    .scl_rise_i(scl_rise),
    .scl_fall_i(scl_fall),
    .sda_oe_o  (sda_oe_o),
    .addr_hit_o(addr_hit),
    .wr_en_o   (wr_en),
    .wr_idx_o  (wr_idx),
    .wr_data_o (wr_data)
  );

  i2c_cmd_store #(.NUM_BYTES(NUM_BYTES)) i_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .stop_i    (stop),
    .addr_hit_i(addr_hit),
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_idx),
    .wr_data_i (wr_data),
    .cmd_o     (cmd_o)
  );

  assign force_o = cmd_o[CW-8+FORCE_BIT];
endmodule

// File: tb/test_i2c_cmd_target.sv
`timescale 1ns/1ps
module test_i2c_cmd_target;
  localparam int H = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_drv = 1'b1, sda_drv = 1'b1;
  logic sda_oe, force_w;
  logic [23:0] cmd;
  logic sda_line;

  always #2.5 clk = ~clk;

  assign sda_line = sda_drv & ~sda_oe;

  i2c_cmd_target i_i2c_cmd_target (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .scl_i   (scl_drv),
    .sda_i   (sda_line),
    .sda_oe_o(sda_oe),
    .cmd_o   (cmd),
    .force_o (force_w)
  );

  int checks = 0, errors = 0;
  int settle = 0;
  bit done = 0;

  // behavioural model
  logic [23:0] m_cmd = '0;
  logic [7:0]  m_hold [3];
  bit m_active = 0, m_pending = 0;
  int m_idx = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wcyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // per-clock comparison of committed word (R5, R10)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (settle > 0) settle--;
      else begin
        chk("R5 cmd vs model", {8'h0, cmd}, {8'h0, m_cmd});
        chk("R10 force follows cmd[19]", {31'h0, force_w}, {31'h0, m_cmd[19]});
      end
    end
  end

  task automatic bus_start();
    sda_drv = 1'b1; wcyc(H);
    scl_drv = 1'b1; wcyc(H);
    sda_drv = 1'b0; wcyc(H);
    scl_drv = 1'b0; wcyc(H);
    m_active = 0;
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; wcyc(H);
    scl_drv = 1'b1; wcyc(H);
    settle = 3 * H;
    sda_drv = 1'b1;
    if (m_pending) begin
      m_cmd = {m_hold[0], m_hold[1], m_hold[2]};
      m_pending = 0;
    end
    m_active = 0;
    wcyc(2 * H);
  endtask

  task automatic send_byte(logic [7:0] b, bit glitch, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_drv = b[i]; wcyc(H);
      scl_drv = 1'b1;
      if (glitch && i == 4) begin
        wcyc(H / 2); scl_drv = 1'b0; wcyc(3); scl_drv = 1'b1; wcyc(H / 2 - 3);
      end else wcyc(H);
      scl_drv = 1'b0;
    end
    sda_drv = 1'b1; wcyc(H);
    scl_drv = 1'b1; wcyc(H / 2);
    ack = ~sda_line;
    wcyc(H / 2);
    scl_drv = 1'b0;
  endtask

  task automatic addr_byte(logic [7:0] b, string req);
    bit ack, exp;
    exp = (b == 8'h36);
    send_byte(b, 1'b0, ack);
    chk(req, {31'h0, ack}, {31'h0, exp});
    if (exp) begin m_active = 1; m_idx = 0; m_pending = 0; end
    else m_active = 0;
  endtask

  task automatic data_byte(logic [7:0] b, bit glitch, string req);
    bit ack, exp;
    exp = m_active;
    send_byte(b, glitch, ack);
    chk(req, {31'h0, ack}, {31'h0, exp});
    if (exp) begin
      m_hold[m_idx] = b;
      m_idx++;
      if (m_idx == 3) begin m_pending = 1; m_active = 0; end
    end
  endtask

  task automatic full_set(logic [7:0] a, logic [7:0] b, logic [7:0] c);
    addr_byte(8'h36, "R1 own address acked");
    data_byte(a, 1'b0, "R4 data byte 1 acked");
    data_byte(b, 1'b0, "R4 data byte 2 acked");
    data_byte(c, 1'b0, "R4 data byte 3 acked");
  endtask

  initial begin
    wcyc(5);
    chk("R10 reset cmd", {8'h0, cmd}, 32'h0);
    chk("R10 reset sda_oe", {31'h0, sda_oe}, 32'h0);
    rst_n = 1'b1;
    wcyc(20);

    // R1 R5 R10: plain write, force bit set
    bus_start(); full_set(8'h08, 8'hA5, 8'h3C); bus_stop();
    chk("R5 field order", {8'h0, cmd}, 32'h0008A53C);
    chk("R10 force_o high", {31'h0, force_w}, 32'h1);

    // R2: R/W=1 and foreign address
    bus_start(); addr_byte(8'h37, "R2 read bit not acked");
    data_byte(8'h11, 1'b0, "R2 byte after read addr not acked"); bus_stop();
    bus_start(); addr_byte(8'h34, "R2 foreign addr not acked");
    data_byte(8'h22, 1'b0, "R2 byte after foreign addr not acked"); bus_stop();
    chk("R2 cmd unchanged", {8'h0, cmd}, 32'h0008A53C);

    // R6: partial transfer then STOP, then bytes without START
    bus_start(); addr_byte(8'h36, "R1 own address acked");
    data_byte(8'hFF, 1'b0, "R4 data byte 1 acked"); bus_stop();
    chk("R6 partial ignored", {8'h0, cmd}, 32'h0008A53C);
    scl_drv = 1'b0; wcyc(H);
    data_byte(8'h36, 1'b0, "R6 no START no ack");
    data_byte(8'h77, 1'b0, "R6 no START no ack");
    scl_drv = 1'b1; wcyc(H);
    chk("R6 cmd unchanged", {8'h0, cmd}, 32'h0008A53C);

    // R4: fourth byte refused; R9 SCL spike inside a byte
    bus_start(); addr_byte(8'h36, "R1 own address acked");
    data_byte(8'h12, 1'b1, "R9 byte with SCL spike acked");
    data_byte(8'h34, 1'b0, "R4 data byte 2 acked");
    data_byte(8'h56, 1'b1, "R9 byte with SCL spike acked");
    data_byte(8'h9A, 1'b0, "R4 fourth byte not acked");
    bus_stop();
    chk("R9 spike did not corrupt", {8'h0, cmd}, 32'h00123456);
    chk("R10 force_o low", {31'h0, force_w}, 32'h0);

    // R9: SDA spike low while idle is no START
    sda_drv = 1'b0; wcyc(3); sda_drv = 1'b1; wcyc(H);
    scl_drv = 1'b0; wcyc(H);
    data_byte(8'h36, 1'b0, "R9 SDA spike no START");
    scl_drv = 1'b1; wcyc(H);

    // R7: held set survives repeated STARTs to others
    bus_start(); full_set(8'hC8, 8'h01, 8'h02);
    bus_start(); addr_byte(8'h50, "R7 other target not acked");
    data_byte(8'h99, 1'b0, "R7 other target data not acked");
    bus_start(); addr_byte(8'h37, "R7 read addr not acked");
    chk("R7 not yet committed", {8'h0, cmd}, 32'h00123456);
    bus_stop();
    chk("R7 committed on later STOP", {8'h0, cmd}, 32'h00C80102);

    // R8: re-address discards waiting set
    bus_start(); full_set(8'h44, 8'h55, 8'h66);
    bus_start(); addr_byte(8'h36, "R8 re-address acked");
    data_byte(8'h0F, 1'b0, "R8 one data byte acked");
    bus_stop();
    chk("R8 STOP after one byte ignored", {8'h0, cmd}, 32'h00C80102);
    bus_start(); full_set(8'hE7, 8'h81, 8'h7E); bus_stop();
    chk("R8 later full set commits", {8'h0, cmd}, 32'h00E7817E);

    wcyc(20);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule